// File: doc/BRIEF.md
# Four-Phase Set-Only Register Stage

This block is a word-wide storage stage built from two cascaded banks of set/clear bits. The front bank (rank A) captures incoming data and the back bank (rank B) drives the output. Neither bank is ever loaded with both polarities of a bit. A bank bit can only be set by an asserted input bit, or cleared together with the rest of its bank. This means the stage needs only the true form of its data and never its complement.

A built-in sequencer runs from one fast system clock. It steps through four phases, one per enabled cycle, and publishes them as one-hot strobes. The phases, in order, are:

- load A from the data input;
- clear B;
- copy A into B;
- clear A.

Loading and clearing never share a phase. Because of this, the output can be routed back into the input of the same stage with no set/clear conflict. A build parameter enables that feedback path. In that mode the front bank captures the external data ORed with the output rotated left by one bit.

Top module: `quad_phase_reg`

## Requirements
- R1: While reset is high and after its release, both banks are cleared, `q` reads all zeros and `valid` is low. The sequencer restarts at phase 1.
- R2: On an enabled phase-1 cycle (`phase_stb` = 4'b0001), every bank-A bit whose load input is 1 becomes 1, and every other bit keeps its value. The data input has no effect in any other phase.
- R3: On an enabled phase-2 cycle (`phase_stb` = 4'b0010), all of bank B is cleared, so `q` reads zero after that edge.
- R4: On an enabled phase-3 cycle (`phase_stb` = 4'b0100), each bank-B bit is set where the matching bank-A bit is 1. After that edge, `q` equals the word loaded in phase 1.
- R5: On an enabled phase-4 cycle (`phase_stb` = 4'b1000), all of bank A is cleared. The next stored word therefore carries no bits from the previous one.
- R6: `phase_stb` carries at most one set bit. While enabled, it steps 0001, 0010, 0100, 1000 and repeats, advancing one phase per clock.
- R7: While `en` is low, `phase_stb` is zero, the phase is held, and neither bank changes. `q` and `valid` keep their values, whatever `din` does.
- R8: `valid` goes high on the edge that ends phase 3 and low on the edge that ends the next phase 2. While it stays high, `q` does not change.
- R9: A bank never receives a load and a clear in the same cycle.
- R10: With `FEEDBACK_ROTATE` = 1, the front bank loads `din | rotl1(q)` in phase 1. Here rotl1 moves bit i to bit i+1 and the top bit to bit 0. After each complete four-phase round, `q` equals that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sequencer enable; low freezes the stage |
| din | input | WIDTH | True-only data input |
| q | output | WIDTH | Stored word from bank B |
| valid | output | 1 | High while `q` holds a settled word |
| phase_stb | output | 4 | One-hot phase strobes, bit 0 = phase 1 |

## Verification
The bench builds two instances.

The first uses the default 40-bit width with feedback off. It covers:
- full-width words, including the all-ones and alternating patterns;
- the clear of the front bank between successive words;
- enable pauses placed in the middle of a round;
- the window where `valid` falls and rises.

The second is an 8-bit instance with feedback rotation enabled. Eight bits keep a full rotation short, so the bench can follow a seeded bit around the whole word, including the wrap from the top bit to bit 0. A model written in the bench predicts each round.

// File: rtl/quad_phase_pkg.sv
package quad_phase_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PH_W = $clog2(NUM_PHASES);

  typedef enum logic [PH_W-1:0] {
    PH_LOAD_A  = 2'd0,
    PH_CLEAR_B = 2'd1,
    PH_COPY_B  = 2'd2,
    PH_CLEAR_A = 2'd3
  } phase_e;
endpackage

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
  import quad_phase_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  output logic [NUM_PHASES-1:0] stb
);
  phase_e ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_LOAD_A;
    else if (en) ph <= phase_e'(ph + 1'b1);
  end

  always_comb begin
    stb = '0;
    if (en) stb[ph] = 1'b1;
  end

  assert_onehot_stb_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));
  assert_advance_R6: assert property (@(posedge clk) disable iff (rst)
    en |=> (ph == phase_e'($past(ph) + 1'b1)));
  assert_hold_phase_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ph));
endmodule

// File: rtl/quad_phase_rank.sv
module quad_phase_rank #(
  parameter int WIDTH = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [WIDTH-1:0] set_bits,
  input  logic             clr,
  output logic [WIDTH-1:0] bits
);
  always_ff @(posedge clk) begin
    if (rst)         bits <= '0;
    else if (clr)    bits <= '0;
    else if (set_en) bits <= bits | set_bits;
  end

  assert_no_merge_R9: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr));
  assert_set_only_R2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((bits & $past(bits)) == $past(bits)));
endmodule

// File: rtl/quad_phase_reg.sv
module quad_phase_reg
  import quad_phase_pkg::*;
#(
  parameter int WIDTH           = 40,
  parameter bit FEEDBACK_ROTATE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [WIDTH-1:0]      din,
  output logic [WIDTH-1:0]      q,
  output logic                  valid,
  output logic [NUM_PHASES-1:0] phase_stb
);
  localparam int TOP = WIDTH - 1;

  function automatic logic [WIDTH-1:0] rotl1(input logic [WIDTH-1:0] v);
    return {v[TOP-1:0], v[TOP]};
  endfunction

  logic [WIDTH-1:0] a_bits;
  logic [WIDTH-1:0] load_word;
  logic load_a, clear_b, copy_b, clear_a;

  quad_phase_seq u_seq (.clk(clk), .rst(rst), .en(en), .stb(phase_stb));

  assign load_a  = phase_stb[PH_LOAD_A];
  assign clear_b = phase_stb[PH_CLEAR_B];
  assign copy_b  = phase_stb[PH_COPY_B];
  assign clear_a = phase_stb[PH_CLEAR_A];

  generate
    if (FEEDBACK_ROTATE) begin : g_fb
      assign load_word = din | rotl1(q);
    end else begin : g_nofb
      assign load_word = din;
    end
  endgenerate

  quad_phase_rank #(.WIDTH(WIDTH)) u_rank_a (
    .clk(clk), .rst(rst), .set_en(load_a), .set_bits(load_word),
    .clr(clear_a), .bits(a_bits));

  quad_phase_rank #(.WIDTH(WIDTH)) u_rank_b (
    .clk(clk), .rst(rst), .set_en(copy_b), .set_bits(a_bits),
    .clr(clear_b), .bits(q));

  always_ff @(posedge clk) begin
    if (rst)          valid <= 1'b0;
    else if (copy_b)  valid <= 1'b1;
    else if (clear_b) valid <= 1'b0;
  end

  assert_jam_a_R2: assert property (@(posedge clk) disable iff (rst)
    load_a |=> (a_bits == ($past(a_bits) | $past(load_word))));
  assert_clear_b_R3: assert property (@(posedge clk) disable iff (rst)
    clear_b |=> (q == '0));
  assert_copy_b_R4: assert property (@(posedge clk) disable iff (rst)
    copy_b |=> (q == $past(a_bits)));
  assert_clear_a_R5: assert property (@(posedge clk) disable iff (rst)
    clear_a |=> (a_bits == '0));
  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(q) && $stable(a_bits) && $stable(valid)));
  assert_valid_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> $stable(q));
endmodule

// File: tb/quad_phase_reg_tb.sv
module quad_phase_reg_tb;
  localparam int W  = 40;
  localparam int FW = 8;
  localparam int NV = 6;
  localparam logic [W-1:0] VEC [0:NV-1] = '{
    40'hA5_5A3C_C301, 40'hFF_FFFF_FFFF, 40'h00_0000_0000,
    40'h80_0000_0001, 40'h55_5555_5555, 40'h12_3456_789A};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic valid;
  logic [3:0] stb;
  logic [FW-1:0] din_f = '0;
  logic [FW-1:0] q_f;
  logic valid_f;
  logic [3:0] stb_f;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  quad_phase_reg #(.WIDTH(W), .FEEDBACK_ROTATE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .en(en), .din(din), .q(q), .valid(valid),
    .phase_stb(stb));

  quad_phase_reg #(.WIDTH(FW), .FEEDBACK_ROTATE(1'b1)) u_fb (
    .clk(clk), .rst(rst), .en(1'b1), .din(din_f), .q(q_f), .valid(valid_f),
    .phase_stb(stb_f));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic logic [FW-1:0] model_fb(input logic [FW-1:0] m,
                                             input logic [FW-1:0] d);
    logic [FW-1:0] r;
    r = m << 1;
    r[0] = m[FW-1];
    return r | d;
  endfunction

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [W-1:0] prev_q;
    logic prev_valid;
    logic [FW-1:0] m;
    repeat (3) @(negedge clk);
    chk(q == '0, "R1 q in reset", 64'(q), 0);
    chk(valid == 1'b0, "R1 valid in reset", 64'(valid), 0);
    rst = 1'b0;
    en  = 1'b1;
    #1;
    chk(stb == 4'b0001, "R1 starts at phase 1", 64'(stb), 64'h1);

    prev_q = '0;
    prev_valid = 1'b0;
    for (int i = 0; i < NV; i++) begin
      din = VEC[i];
      @(negedge clk);
      din = ~VEC[i];
      chk(stb == 4'b0010, "R6 phase 2 strobe", 64'(stb), 64'h2);
      chk(q == prev_q, "R8 q holds in phase 1", 64'(q), 64'(prev_q));
      chk(valid == prev_valid, "R8 valid through phase 1", 64'(valid), 64'(prev_valid));
      @(negedge clk);
      chk(stb == 4'b0100, "R6 phase 3 strobe", 64'(stb), 64'h4);
      chk(q == '0, "R3 B cleared", 64'(q), 0);
      chk(valid == 1'b0, "R8 valid low after phase 2", 64'(valid), 0);
      @(negedge clk);
      chk(stb == 4'b1000, "R6 phase 4 strobe", 64'(stb), 64'h8);
      chk(q == VEC[i], "R4 B copies A / R2 / R5", 64'(q), 64'(VEC[i]));
      chk(valid == 1'b1, "R8 valid after phase 3", 64'(valid), 1);
      if (i == 2) begin
        en = 1'b0;
        din = '1;
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          chk(stb == 4'b0000, "R7 no strobe while disabled", 64'(stb), 0);
          chk(q == VEC[i], "R7 q frozen", 64'(q), 64'(VEC[i]));
          chk(valid == 1'b1, "R7 valid frozen", 64'(valid), 1);
        end
        en = 1'b1;
        #1;
        chk(stb == 4'b1000, "R7 phase held", 64'(stb), 64'h8);
      end
      @(negedge clk);
      chk(stb == 4'b0001, "R6 wraps to phase 1", 64'(stb), 64'h1);
      chk(q == VEC[i], "R8 q stable in phase 4", 64'(q), 64'(VEC[i]));
      prev_q = VEC[i];
      prev_valid = 1'b1;
    end

    en = 1'b0;
    din = '1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    din = '0;
    repeat (3) @(negedge clk);
    chk(q == '0, "R2 din ignored while disabled, R5 A cleared", 64'(q), 0);
    @(negedge clk);

    while (stb_f != 4'b0001) @(negedge clk);
    m = '0;
    for (int r = 0; r < 10; r++) begin
      din_f = (r == 0) ? 8'h81 : ((r == 4) ? 8'h10 : 8'h00);
      m = model_fb(m, din_f);
      repeat (3) @(negedge clk);
      chk(q_f == m, "R10 feedback rotate round", 64'(q_f), 64'(m));
      chk(valid_f == 1'b1, "R10 feedback valid", 64'(valid_f), 1);
      @(negedge clk);
    end

    rst = 1'b1;
    @(negedge clk);
    chk(q == '0 && q_f == '0, "R1 reset clears output", 64'(q), 0);
    chk(valid == 1'b0, "R1 reset clears valid", 64'(valid), 0);
    summary();
  end
endmodule